// File: doc/BRIEF.md
# Key-Protected Watchdog and Interval Timer

This block is an 8-bit up-counter controlled by one 32-bit control/status word. It runs either as a watchdog or as an interval timer. While the timer is enabled, the counter advances on each cycle in which the prescaled `tick` input is high. When the counter wraps from its maximum value back to zero, the block raises the overflow flag that matches the current mode:

- In watchdog mode it also issues a reset request for a fixed number of cycles. The reset is of a selectable type.
- In interval mode it holds an interrupt line high until software clears the flag.

The control word is guarded against stray stores. A write goes through only when all four byte lanes are enabled and the top byte of the data carries the key value 0xA5. Any other write leaves the word untouched.

The control word is cleared only by the power-on reset input. The secondary reset clears the counter and the reset-request pulse but leaves the control word as it was, so a reset that the watchdog itself caused does not erase the record of why it happened.

Top module: `guard_timer`

## Requirements
- R1: A write with `wr_be` other than 4'b1111 leaves the control word unchanged, even if it carries the key.
- R2: A full-word write whose bits 31:24 differ from 0xA5 leaves the control word unchanged.
- R3: The read word places the enable at bit 7, the mode at bit 6 (1 = watchdog, 0 = interval), the reset type at bit 5, the watchdog overflow flag at bit 4 and the interval overflow flag at bit 3. Bits 31:8 and 2:0 always read 0.
- R4: With enable at 0, or with `tick` low, the count holds. With enable at 1, the count rises by one on each clock edge at which `tick` is high.
- R5: In interval mode, a wrap from 0xFF to 0x00 sets bit 3. `irq` is high exactly while bit 3 is set.
- R6: In watchdog mode, a wrap sets bit 4. From the next cycle on, `rst_req` is high for exactly 4 cycles, and `rst_kind` carries the value that bit 5 had at the wrap (0 = power-on type, 1 = manual type).
- R7: A keyed write of 0 to a flag clears it. A keyed write of 1 to a flag leaves it as it was, so a flag cannot be set by software.
- R8: A keyed write that changes the mode while enable is 1 is accepted and restarts the count from 0. A keyed write that keeps the mode does not disturb the count.
- R9: `soft_rst_n` low clears the count and the reset request but not the control word. `por_n` low clears everything.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| soft_rst_n | input | 1 | Secondary reset, active low, clears the count and the pulse only |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data, key in bits 31:24 |
| rd_data | output | 32 | Current control word |
| count | output | 8 | Current counter value |
| rst_req | output | 1 | Reset request pulse from a watchdog overflow |
| rst_kind | output | 1 | Type of the requested reset |
| irq | output | 1 | Interval-overflow interrupt |

## Verification
A wrongly accepted write shows up on `rd_data` in the cycle right after the write. This is why every key value and every byte-enable pattern is swept, with a read-back after each one.

A count that has drifted by even one step moves the overflow. Both the flag and the reset or interrupt output then appear one cycle early or late against an arithmetically predicted tick number. A stuck pulse counter or a wrongly latched reset type is seen in the same cycle on `rst_req` and `rst_kind`, since the width of the pulse is counted at the ports.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;
  localparam logic [7:0] KEY = 8'hA5;

  // bit positions inside the control word
  localparam int B_EN   = 7;
  localparam int B_MODE = 6;
  localparam int B_RSEL = 5;
  localparam int B_WOVF = 4;
  localparam int B_IOVF = 3;

  function automatic logic key_ok(input logic [BE_W-1:0] be,
                                  input logic [WORD_W-1:0] d);
    return (&be) && (d[WORD_W-1 -: 8] == KEY);
  endfunction

  function automatic logic at_top(input logic [7:0] c, input int w);
    return c == 8'((1 << w) - 1);
  endfunction
endpackage

// File: rtl/guard_counter.sv
module guard_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign wrap = run && tick && !restart && (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (restart)       count <= '0;
    else if (run && tick)   count <= count + 1'b1;
  end

  // R4: disabled counter holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(count));
  // R8: a restart leaves the counter at zero
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));
  // R4: a wrap leaves the counter at zero
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));
endmodule

// File: rtl/guard_pulse.sv
module guard_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic kind_in,
  output logic req,
  output logic kind
);
  localparam int PW = $clog2(LEN + 1);
  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
      kind <= 1'b0;
    end else if (fire) begin
      left <= PW'(LEN);
      kind <= kind_in;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign req = (left != '0);

  // R6: the pulse starts only after a watchdog wrap
  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(fire));
  // R6: the type is steady while the pulse runs
  assert_kind_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !$past(fire)) |-> $stable(kind));
endmodule

// File: rtl/guard_csr.sv
module guard_csr
  import guard_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wrap,
  output logic              en,
  output logic              mode,
  output logic              rsel,
  output logic              wovf,
  output logic              iovf,
  output logic              restart,
  output logic              wd_fire,
  output logic [WORD_W-1:0] rd_data
);
  logic accept;
  logic iv_fire;

  assign accept  = wr_en && key_ok(wr_be, wr_data);
  assign restart = accept && en && (wr_data[B_MODE] != mode);
  assign wd_fire = wrap && mode;
  assign iv_fire = wrap && !mode;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en <= 1'b0; mode <= 1'b0; rsel <= 1'b0; wovf <= 1'b0; iovf <= 1'b0;
    end else begin
      if (accept) begin
        en   <= wr_data[B_EN];
        mode <= wr_data[B_MODE];
        rsel <= wr_data[B_RSEL];
      end
      if (wd_fire)                          wovf <= 1'b1;
      else if (accept && !wr_data[B_WOVF])  wovf <= 1'b0;
      if (iv_fire)                          iovf <= 1'b1;
      else if (accept && !wr_data[B_IOVF])  iovf <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[B_EN]   = en;
    rd_data[B_MODE] = mode;
    rd_data[B_RSEL] = rsel;
    rd_data[B_WOVF] = wovf;
    rd_data[B_IOVF] = iovf;
  end

  // R1 R2: rejected writes leave the word alone
  assert_reject_R2: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !((&wr_be) && wr_data[31:24] == KEY) && !wrap)
      |=> $stable({en, mode, rsel, wovf, iovf}));
  // R7: software cannot raise a flag
  assert_no_sw_set_R7: assert property (@(posedge clk) disable iff (!por_n)
    !wrap |=> !$rose(wovf) && !$rose(iovf));
  // R5: interval flag rises only from an interval-mode wrap
  assert_iflag_src_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(iovf) |-> $past(wrap && !mode));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              rst_req,
  output logic              rst_kind,
  output logic              irq
);
  logic en, mode, rsel, wovf, iovf;
  logic restart, wd_fire, wrap;
  logic run_rst_n;

  assign run_rst_n = por_n && soft_rst_n;

  guard_csr u_csr (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .wrap(wrap), .en(en), .mode(mode), .rsel(rsel),
    .wovf(wovf), .iovf(iovf), .restart(restart), .wd_fire(wd_fire),
    .rd_data(rd_data)
  );

  guard_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(run_rst_n), .run(en), .tick(tick),
    .restart(restart), .count(count), .wrap(wrap)
  );

  guard_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(run_rst_n), .fire(wd_fire), .kind_in(rsel),
    .req(rst_req), .kind(rst_kind)
  );

  assign irq = iovf;

  // R6: a watchdog wrap leaves its flag set
  assert_wflag_R6: assert property (@(posedge clk) disable iff (!run_rst_n)
    (wrap && mode) |=> wovf);
endmodule

// File: tb/test_guard_timer.sv
module test_guard_timer;
  logic clk = 1'b0;
  logic por_n = 1'b0, soft_rst_n = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  count;
  logic rst_req, rst_kind, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  guard_timer i_guard_timer (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .tick(tick),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
    .count(count), .rst_req(rst_req), .rst_kind(rst_kind), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input bit e, m, r, wf, ifl);
    return (32'(e) << 7) | (32'(m) << 6) | (32'(r) << 5) | (32'(wf) << 4) | (32'(ifl) << 3);
  endfunction

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic wd_pulse(input bit kind);
    int high = 0;
    ticks(1);
    chk("R6 rst_req first cycle", 32'(rst_req), 32'd1);
    chk("R6 rst_kind", 32'(rst_kind), 32'(kind));
    for (int i = 0; i < 8; i++) begin
      if (rst_req) high++;
      @(negedge clk);
    end
    chk("R6 pulse width", 32'(high), 32'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R9 por word", rd_data, 32'h0);
    chk("R9 por count", 32'(count), 32'h0);
    chk("R9 por outputs", {29'h0, rst_req, rst_kind, irq}, 32'h0);

    for (int b = 0; b < 15; b++) begin
      wr(4'(b), 32'hA5FF_FFE0);
      chk("R1 partial write", rd_data, 32'h0);
    end
    for (int k = 0; k < 256; k++) begin
      if (k != 8'hA5) begin
        wr(4'hF, {8'(k), 24'hFF_FFE0});
        chk("R2 wrong key", rd_data, 32'h0);
      end
    end
    wr(4'hF, 32'hA5FF_FF18);
    chk("R7 flags not settable, R3 zero fields", rd_data, 32'h0);

    wr(4'hF, 32'hA500_0080);
    chk("R3 enable readback", rd_data, word(1, 0, 0, 0, 0));
    ticks(10);
    chk("R4 count 10", 32'(count), 32'd10);
    repeat (5) @(negedge clk);
    chk("R4 tick low holds", 32'(count), 32'd10);
    ticks(245);
    chk("R4 count 255", 32'(count), 32'd255);
    chk("R5 no irq yet", 32'(irq), 32'd0);
    ticks(1);
    chk("R5 wrap count", 32'(count), 32'd0);
    chk("R5 iflag", rd_data, word(1, 0, 0, 0, 1));
    chk("R5 irq", 32'(irq), 32'd1);
    ticks(3);
    chk("R5 irq held", 32'(irq), 32'd1);
    chk("R6 no rst in interval", 32'(rst_req), 32'd0);

    wr(4'hF, 32'hA500_0088);
    chk("R7 write one keeps", rd_data, word(1, 0, 0, 0, 1));
    wr(4'hF, 32'hA500_0080);
    chk("R7 write zero clears", rd_data, word(1, 0, 0, 0, 0));
    chk("R5 irq drops", 32'(irq), 32'd0);

    wr(4'hF, 32'hA500_00C0);
    chk("R8 mode change restarts", 32'(count), 32'd0);
    chk("R8 word", rd_data, word(1, 1, 0, 0, 0));
    ticks(5);
    wr(4'hF, 32'hA500_00E0);
    chk("R8 same mode keeps count", 32'(count), 32'd5);

    ticks(250);
    chk("R6 count 255", 32'(count), 32'd255);
    chk("R6 no rst yet", 32'(rst_req), 32'd0);
    wd_pulse(1'b1);
    chk("R6 wflag", rd_data, word(1, 1, 1, 1, 0));

    ticks(7 - 32'(count));
    chk("R9 count before soft", 32'(count), 32'd7);
    @(negedge clk); soft_rst_n = 1'b0;
    @(negedge clk); soft_rst_n = 1'b1;
    chk("R9 soft clears count", 32'(count), 32'd0);
    chk("R9 soft keeps word", rd_data, word(1, 1, 1, 1, 0));

    wr(4'hF, 32'hA500_00C0);
    chk("R7 wflag cleared", rd_data, word(1, 1, 0, 0, 0));
    ticks(255);
    wd_pulse(1'b0);

    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    chk("R9 por clears word", rd_data, 32'h0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule